// File: doc/BRIEF.md
# Thermal Trip Monitor with Offsetting

This block watches a set of on-die temperature readings, each a signed value in milli-degrees Celsius. Every sensor has a pair of alarm levels. Going above the lower "hot" level raises a throttle request for that sensor. Going above the upper "critical" level raises a critical request for that sensor. Each request has hysteresis, so it drops only once the reading falls below its level minus a programmed margin. Any critical request sets a single thermal-trip output for the power management IC, and that output stays set until reset.

One sensor is the reference. Any other sensor can be switched into offset mode. In offset mode its reported value is the reference reading plus a signed per-sensor offset, limited to a programmed lower and upper bound. Offset mode takes effect only when it is enabled and the lower bound does not exceed the upper bound. The reference sensor always reports its own raw reading.

All levels, margins and offset settings are loaded through a write-only configuration port. The reported (possibly offset) temperatures are brought out so that the offset path can be observed.

Top module: `tmon_top`

## Requirements
- R1: After reset, every throttle request, every critical request and the thermal-trip output are 0, and every reported temperature is 0. Each sensor's hot level is 100000, its critical level is 102500, its margin is 1000, its offset settings are zero and offset mode is off.
- R2: A sensor with offset mode off reports its own raw reading unchanged, including negative values.
- R3: A sensor with valid offset mode reports the reference reading plus its offset. The sum is limited to no less than its lower bound and no more than its upper bound.
- R4: The reference sensor (index 0 by default) ignores its own offset settings and always reports its raw reading.
- R5: When a sensor's lower bound is greater than its upper bound, offset mode is forced off and the sensor reports its raw reading.
- R6: A throttle request is set when the reported temperature is strictly greater than the hot level. A reading equal to the level does not set it.
- R7: A set throttle request clears only when the reported temperature is strictly below the hot level minus the margin. Between those two points it holds its value.
- R8: A critical request follows the same rule as R6 and R7, using the critical level and the same margin.
- R9: The thermal-trip output becomes 1 in the cycle after any critical request is 1. It then stays 1 until reset, even after every critical request has cleared.
- R10: A configuration write with `cfgWe` = 1 sets the field chosen by `cfgAddr[2:0]` for the sensor in `cfgAddr[4:3]`. The field codes are 0 = hot level, 1 = critical level, 2 = margin (low 19 bits, unsigned), 3 = offset, 4 = lower bound, 5 = upper bound, 6 = control (bit 0 enables offset mode).
- R11: A new raw reading appears on `repTempOut` one clock after it is sampled. The requests respond to it one clock after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sensTempIn | input | 80 | Raw readings, sensor i in bits [20i+19:20i], signed milli-degrees |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 5 | Sensor index in bits [4:3], field code in bits [2:0] |
| cfgWdata | input | 20 | Configuration write value |
| repTempOut | output | 80 | Reported temperature per sensor, same packing as the input |
| throttleReq | output | 4 | Throttle request per sensor |
| critReq | output | 4 | Critical request per sensor |
| thermTrip | output | 1 | Latched thermal-trip to the power management IC |

## Verification
Directed readings are placed exactly on the hot level, one above it, exactly on the hysteresis edge and one below it. These cases separate a strict compare from an inclusive one, and holding in the band from clearing early. Offset sums are driven below the lower bound, inside the window and above the upper bound, which shows whether the clamp and the sign extension are correct. The bench also offsets the reference sensor and inverts the bounds, so offsetting that is not gated off would show up. Random readings mixed with random configuration writes, spread around the levels, cover hysteresis paths that pass through state changed by the configuration, and a latency probe confirms the one-cycle reporting and two-cycle request timing.

// File: rtl/tmon_pkg.sv
package tmon_pkg;
  parameter int TEMP_W = 20;

  typedef logic signed [TEMP_W-1:0] temp_t;

  typedef enum logic [2:0] {
    FLD_HOT  = 3'd0,
    FLD_CRIT = 3'd1,
    FLD_HYST = 3'd2,
    FLD_OFFS = 3'd3,
    FLD_LOW  = 3'd4,
    FLD_HIGH = 3'd5,
    FLD_CTRL = 3'd6
  } cfgField_e;

  typedef struct packed {
    temp_t hot;
    temp_t crit;
    temp_t hyst;
    temp_t offs;
    temp_t lowB;
    temp_t highB;
    logic  offEn;
  } sensCfg_t;

  // Compare strobes passed from the datapath to the control
  typedef struct packed {
    logic hotAbove;
    logic hotBelow;
    logic critAbove;
    logic critBelow;
  } cmpStrobe_t;
endpackage

// File: rtl/tmon_regs.sv
module tmon_regs
  import tmon_pkg::*;
#(
  parameter int NUM_SENS   = 4,
  parameter int RESET_HOT  = 100000,
  parameter int RESET_CRIT = 102500,
  parameter int RESET_HYST = 1000,
  localparam int SIDX_W = (NUM_SENS > 1) ? $clog2(NUM_SENS) : 1,
  localparam int ADDR_W = SIDX_W + 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [TEMP_W-1:0] cfgWdata,
  output sensCfg_t          cfg [NUM_SENS]
);
  cfgField_e fieldSel;
  logic [SIDX_W-1:0] sensSel;

  assign fieldSel = cfgField_e'(cfgAddr[2:0]);
  assign sensSel  = cfgAddr[ADDR_W-1:3];

  for (genvar g = 0; g < NUM_SENS; g++) begin : g_sens
    logic hit;
    assign hit = cfgWe && (sensSel == SIDX_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cfg[g].hot   <= temp_t'(RESET_HOT);
        cfg[g].crit  <= temp_t'(RESET_CRIT);
        cfg[g].hyst  <= temp_t'(RESET_HYST);
        cfg[g].offs  <= '0;
        cfg[g].lowB  <= '0;
        cfg[g].highB <= '0;
        cfg[g].offEn <= 1'b0;
      end else if (hit) begin
        case (fieldSel)
          FLD_HOT:  cfg[g].hot   <= cfgWdata;
          FLD_CRIT: cfg[g].crit  <= cfgWdata;
          FLD_HYST: cfg[g].hyst  <= {1'b0, cfgWdata[TEMP_W-2:0]};
          FLD_OFFS: cfg[g].offs  <= cfgWdata;
          FLD_LOW:  cfg[g].lowB  <= cfgWdata;
          FLD_HIGH: cfg[g].highB <= cfgWdata;
          FLD_CTRL: cfg[g].offEn <= cfgWdata[0];
          default:  ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tmon_dp.sv
module tmon_dp
  import tmon_pkg::*;
#(
  parameter int NUM_SENS = 4,
  parameter int REF_IDX  = 0
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_SENS*TEMP_W-1:0] sensRaw,
  input  sensCfg_t                   cfg     [NUM_SENS],
  output temp_t                      repTemp [NUM_SENS],
  output cmpStrobe_t                 strobe  [NUM_SENS]
);
  localparam int WW = TEMP_W + 1;
  typedef logic signed [WW-1:0] wide_t;

  temp_t refRaw;
  assign refRaw = sensRaw[REF_IDX*TEMP_W +: TEMP_W];

  for (genvar g = 0; g < NUM_SENS; g++) begin : g_lane
    localparam bit IS_REF = (g == REF_IDX);

    temp_t rawV, nextV;
    wide_t sumW, lowW, highW;
    wide_t repW, hotW, critW, hystW;
    logic  offsetOn;

    assign rawV     = sensRaw[g*TEMP_W +: TEMP_W];
    assign offsetOn = !IS_REF && cfg[g].offEn &&
                      ($signed(cfg[g].lowB) <= $signed(cfg[g].highB));
    assign lowW  = WW'($signed(cfg[g].lowB));
    assign highW = WW'($signed(cfg[g].highB));
    assign sumW  = WW'($signed(refRaw)) + WW'($signed(cfg[g].offs));

    always_comb begin
      if (!offsetOn)          nextV = rawV;
      else if (sumW < lowW)   nextV = cfg[g].lowB;
      else if (sumW > highW)  nextV = cfg[g].highB;
      else                    nextV = temp_t'(sumW);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) repTemp[g] <= '0;
      else       repTemp[g] <= nextV;
    end

    assign repW  = WW'($signed(repTemp[g]));
    assign hotW  = WW'($signed(cfg[g].hot));
    assign critW = WW'($signed(cfg[g].crit));
    assign hystW = WW'($signed(cfg[g].hyst));

    assign strobe[g].hotAbove  = repW > hotW;
    assign strobe[g].hotBelow  = repW < (hotW - hystW);
    assign strobe[g].critAbove = repW > critW;
    assign strobe[g].critBelow = repW < (critW - hystW);

    AST_OFFSET_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
      offsetOn |=> ($signed(repTemp[g]) >= $signed($past(cfg[g].lowB)) &&
                    $signed(repTemp[g]) <= $signed($past(cfg[g].highB)))); // R3
  end
endmodule

// File: rtl/tmon_ctrl.sv
module tmon_ctrl
  import tmon_pkg::*;
#(
  parameter int NUM_SENS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  cmpStrobe_t          strobe [NUM_SENS],
  output logic [NUM_SENS-1:0] throttleReq,
  output logic [NUM_SENS-1:0] critReq,
  output logic                thermTrip
);
  for (genvar g = 0; g < NUM_SENS; g++) begin : g_state
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                   throttleReq[g] <= 1'b0;
      else if (strobe[g].hotAbove) throttleReq[g] <= 1'b1;
      else if (strobe[g].hotBelow) throttleReq[g] <= 1'b0;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                    critReq[g] <= 1'b0;
      else if (strobe[g].critAbove) critReq[g] <= 1'b1;
      else if (strobe[g].critBelow) critReq[g] <= 1'b0;
    end

    AST_THR_SET: assert property (@(posedge clk) disable iff (!rstN)
      strobe[g].hotAbove |=> throttleReq[g]); // R6
    AST_THR_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
      strobe[g].hotBelow |=> !throttleReq[g]); // R7
    AST_THR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      !(strobe[g].hotAbove || strobe[g].hotBelow) |=> $stable(throttleReq[g])); // R7
    AST_CRIT_SET: assert property (@(posedge clk) disable iff (!rstN)
      strobe[g].critAbove |=> critReq[g]); // R8
    AST_TRIP_FROM_CRIT: assert property (@(posedge clk) disable iff (!rstN)
      critReq[g] |=> thermTrip); // R9
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         thermTrip <= 1'b0;
    else if (|critReq) thermTrip <= 1'b1;
  end

  AST_TRIP_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    thermTrip |=> thermTrip); // R9
endmodule

// File: rtl/tmon_top.sv
module tmon_top
  import tmon_pkg::*;
#(
  parameter int NUM_SENS   = 4,
  parameter int REF_IDX    = 0,
  parameter int RESET_HOT  = 100000,
  parameter int RESET_CRIT = 102500,
  parameter int RESET_HYST = 1000,
  localparam int SIDX_W = (NUM_SENS > 1) ? $clog2(NUM_SENS) : 1,
  localparam int ADDR_W = SIDX_W + 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_SENS*TEMP_W-1:0] sensTempIn,
  input  logic                       cfgWe,
  input  logic [ADDR_W-1:0]          cfgAddr,
  input  logic [TEMP_W-1:0]          cfgWdata,
  output logic [NUM_SENS*TEMP_W-1:0] repTempOut,
  output logic [NUM_SENS-1:0]        throttleReq,
  output logic [NUM_SENS-1:0]        critReq,
  output logic                       thermTrip
);
  sensCfg_t   cfg     [NUM_SENS];
  temp_t      repTemp [NUM_SENS];
  cmpStrobe_t strobe  [NUM_SENS];

  tmon_regs #(
    .NUM_SENS(NUM_SENS), .RESET_HOT(RESET_HOT),
    .RESET_CRIT(RESET_CRIT), .RESET_HYST(RESET_HYST)
  ) uRegs (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .cfg(cfg)
  );

  tmon_dp #(.NUM_SENS(NUM_SENS), .REF_IDX(REF_IDX)) uDp (
    .clk(clk), .rstN(rstN), .sensRaw(sensTempIn), .cfg(cfg),
    .repTemp(repTemp), .strobe(strobe)
  );

  tmon_ctrl #(.NUM_SENS(NUM_SENS)) uCtrl (
    .clk(clk), .rstN(rstN), .strobe(strobe), .throttleReq(throttleReq),
    .critReq(critReq), .thermTrip(thermTrip)
  );

  for (genvar g = 0; g < NUM_SENS; g++) begin : g_flat
    assign repTempOut[g*TEMP_W +: TEMP_W] = repTemp[g];
  end
endmodule

// File: tb/tb_tmon_top.sv
`timescale 1ns/1ps
module tb_tmon_top;
  import tmon_pkg::*;
  localparam int N = 4, W = TEMP_W, REF = 0, SW = 2;
  localparam int HYST_MASK = (1 << (W-1)) - 1;

  logic clk = 1'b0, rstN = 1'b0, cfgWe = 1'b0;
  logic [N*W-1:0] sensTempIn = '0;
  logic [SW+2:0]  cfgAddr = '0;
  logic [W-1:0]   cfgWdata = '0;
  logic [N*W-1:0] repTempOut;
  logic [N-1:0]   throttleReq, critReq;
  logic           thermTrip;

  always #2.5 clk = ~clk;

  tmon_top dut (
    .clk(clk), .rstN(rstN), .sensTempIn(sensTempIn), .cfgWe(cfgWe),
    .cfgAddr(cfgAddr), .cfgWdata(cfgWdata), .repTempOut(repTempOut),
    .throttleReq(throttleReq), .critReq(critReq), .thermTrip(thermTrip)
  );

  int cHot[N], cCrit[N], cHyst[N], cOffs[N], cLow[N], cHigh[N];
  bit cEn[N];
  int rawT[N], prevRep[N];
  bit mThr[N], mCrit[N], mTrip;
  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  function automatic int expRep(int i);
    int s;
    if (i == REF || !cEn[i] || cLow[i] > cHigh[i]) return rawT[i];
    s = rawT[REF] + cOffs[i];
    if (s < cLow[i]) return cLow[i];
    if (s > cHigh[i]) return cHigh[i];
    return s;
  endfunction

  function automatic bit upd(bit st, int v, int lvl, int hy);
    if (v > lvl) return 1'b1;
    if (v < lvl - hy) return 1'b0;
    return st;
  endfunction

  task automatic modelDefaults();
    for (int i = 0; i < N; i++) begin
      cHot[i] = 100000; cCrit[i] = 102500; cHyst[i] = 1000;
      cOffs[i] = 0; cLow[i] = 0; cHigh[i] = 0; cEn[i] = 1'b0;
      mThr[i] = 1'b0; mCrit[i] = 1'b0; prevRep[i] = 0;
    end
    mTrip = 1'b0;
  endtask

  task automatic settle();
    for (int i = 0; i < N; i++) begin
      mThr[i]  = upd(mThr[i],  prevRep[i], cHot[i],  cHyst[i]);
      mCrit[i] = upd(mCrit[i], prevRep[i], cCrit[i], cHyst[i]);
      if (mCrit[i]) mTrip = 1'b1;
    end
    for (int i = 0; i < N; i++) begin
      prevRep[i] = expRep(i);
      mThr[i]  = upd(mThr[i],  prevRep[i], cHot[i],  cHyst[i]);
      mCrit[i] = upd(mCrit[i], prevRep[i], cCrit[i], cHyst[i]);
      if (mCrit[i]) mTrip = 1'b1;
    end
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int repOf(int i);
    logic signed [W-1:0] v;
    v = repTempOut[i*W +: W];
    return int'(v);
  endfunction

  task automatic checkAll(string tag);
    for (int i = 0; i < N; i++) begin
      chk(tag, $sformatf("rep[%0d]", i), repOf(i), prevRep[i]);
      chk(tag, $sformatf("throttle[%0d]", i), int'(throttleReq[i]), int'(mThr[i]));
      chk(tag, $sformatf("crit[%0d]", i), int'(critReq[i]), int'(mCrit[i]));
    end
    chk(tag, "thermTrip", int'(thermTrip), int'(mTrip));
  endtask

  task automatic driveRaw();
    for (int i = 0; i < N; i++) sensTempIn[i*W +: W] = W'(rawT[i]);
  endtask

  task automatic step(string tag);
    driveRaw();
    repeat (4) @(negedge clk);
    settle();
    checkAll(tag);
  endtask

  task automatic cfgWrite(string tag, int s, cfgField_e f, int v);
    cfgAddr = {SW'(s), f};
    cfgWdata = W'(v);
    cfgWe = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0;
    case (f)
      FLD_HOT:  cHot[s]  = v;
      FLD_CRIT: cCrit[s] = v;
      FLD_HYST: cHyst[s] = v & HYST_MASK;
      FLD_OFFS: cOffs[s] = v;
      FLD_LOW:  cLow[s]  = v;
      FLD_HIGH: cHigh[s] = v;
      FLD_CTRL: cEn[s]   = v[0];
      default:  ;
    endcase
    repeat (3) @(negedge clk);
    settle();
    checkAll(tag);
  endtask

  task automatic doReset(string tag);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    modelDefaults();
    checkAll(tag);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    settle();
    checkAll(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < N; i++) rawT[i] = 20000;
    driveRaw();
    @(negedge clk);
    doReset("R1 reset state");

    // R6 strict compare against default hot level
    rawT[1] = 100000; step("R6 equal to hot");
    rawT[1] = 100001; step("R6 above hot");
    // R7 hysteresis band
    rawT[1] = 99000;  step("R7 on band edge holds");
    rawT[1] = 98999;  step("R7 below band clears");
    // R8 / R9 critical path and latch
    rawT[2] = 102501; step("R8 R9 above critical");
    rawT[2] = 101500; step("R8 critical holds in band");
    rawT[2] = 101499; step("R8 R9 critical clears, trip stays");
    // R2 negative raw
    rawT[3] = -12345; step("R2 negative raw reading");

    // R3 offset with clamp
    cfgWrite("R10 R3 offset", 1, FLD_OFFS, -3000);
    cfgWrite("R10 R3 low", 1, FLD_LOW, 90000);
    cfgWrite("R10 R3 high", 1, FLD_HIGH, 105000);
    cfgWrite("R10 R3 enable", 1, FLD_CTRL, 1);
    rawT[0] = 100000; step("R3 inside window");
    rawT[0] = 110000; step("R3 clamp high");
    rawT[0] = 50000;  step("R3 clamp low");

    // R4 reference ignores own offset
    cfgWrite("R4 ref offset", 0, FLD_OFFS, 5000);
    cfgWrite("R4 ref low", 0, FLD_LOW, -100);
    cfgWrite("R4 ref high", 0, FLD_HIGH, 100);
    cfgWrite("R4 ref enable", 0, FLD_CTRL, 1);
    rawT[0] = 101000; step("R4 reference raw");

    // R5 inverted bounds disable offsetting
    cfgWrite("R5 inverted bounds", 1, FLD_LOW, 106000);
    rawT[1] = 77777; step("R5 raw when bounds inverted");

    // R10 field decode for another sensor
    cfgWrite("R10 hot of sensor 3", 3, FLD_HOT, 0);
    rawT[3] = 10; step("R10 new hot level used");

    // R11 latency probe on sensor 2
    rawT[2] = 20000; step("R11 prepare");
    rawT[2] = 100500;
    driveRaw();
    @(negedge clk);
    chk("R11 rep after one clock", "rep[2]", repOf(2), 100500);
    chk("R11 throttle not yet", "throttle[2]", int'(throttleReq[2]), 0);
    @(negedge clk);
    chk("R11 throttle after two clocks", "throttle[2]", int'(throttleReq[2]), 1);
    repeat (2) @(negedge clk);
    settle();
    checkAll("R11 settled");

    doReset("R9 R1 reset clears trip");

    // Random phase
    for (int it = 0; it < 240; it++) begin
      if (it % 60 == 59) doReset("R1 random reset");
      if ($urandom_range(3) == 0) begin
        int s, f, v;
        s = $urandom_range(N-1);
        f = $urandom_range(6);
        case (f)
          0: v = 95000 + int'($urandom_range(10000));
          1: v = 98000 + int'($urandom_range(12000));
          2: v = int'($urandom_range(3000));
          3: v = int'($urandom_range(12000)) - 6000;
          4: v = 85000 + int'($urandom_range(15000));
          5: v = 95000 + int'($urandom_range(17000));
          default: v = int'($urandom_range(1));
        endcase
        cfgWrite("R3 R5 R10 random config", s, cfgField_e'(f[2:0]), v);
      end else begin
        for (int i = 0; i < N; i++) rawT[i] = 85000 + int'($urandom_range(30000));
        step("R6 R7 R8 R9 random readings");
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule